// File: doc/BRIEF.md
# NAND Page Boot Loader Sequencer

This block copies a boot image out of a raw small-page NAND flash into a destination memory with no processor involvement. A single `start` pulse latches the first page number, the page size, the byte count and the destination base address. The block then turns on its controller-enable output, resets the flash device and waits for it to report ready. After that it reads pages one after another. For every page it issues the read opcode and four address cycles, waits for the ready line, then reads the page a byte at a time. Each byte is written to consecutive destination addresses through a simple write port.

The loop ends when the remaining byte count falls below zero after a page has been subtracted. A count that is an exact multiple of the page size therefore loads one more page than strictly needed. When the last page is done, chip enable goes high and the controller-enable output drops. One cycle later `done` pulses for a single cycle.

Top module: `nand_boot_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it, `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1, `nand_cle`, `nand_ale`, `ctl_en`, `mem_we` and `done` are 0.
- R2: After `start`, `ctl_en` rises, opcode 0xFF is written exactly once with `nand_cle` high, the block waits for `nand_rb`=1, and `nand_ce_n` returns high once before the first page.
- R3: Each page begins with opcode 0x00 latched with `nand_cle` high, followed by exactly four bytes latched with `nand_ale` high; `nand_ce_n` returns high once at the end of each page.
- R4: With offset = page × page_size (33 bits, zero-extended), the four address bytes are, in order, offset[7:0], offset[16:9], offset[24:17], offset[32:25]; bit 8 is never sent.
- R5: No read strobe (`nand_re_n` low) occurs while the device reports busy (`nand_rb`=0) after a command or address sequence.
- R6: Page bytes are sampled on `nand_din` while `nand_re_n` is low and written with `mem_we` to consecutive addresses starting at `dest_base`, in read order, across page boundaries.
- R7: The number of pages read is floor(byte_count / page_size) + 1, and exactly that many × page_size bytes are written; an exact multiple reads one extra page.
- R8: At the end, `nand_ce_n` is 1 and `ctl_en` is 0, and `done` is high for exactly one cycle, in the cycle after `ctl_en` fell.
- R9: A `start` pulse while a load is in progress is ignored: the running load keeps its parameters and the reset opcode is not reissued.
- R10: `nand_cle` and `nand_ale` are never both high, `nand_we_n` and `nand_re_n` are never both low, and either strobe is low only while `nand_ce_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (ignored while busy) |
| start_page | input | PAGE_W | First page number |
| page_size | input | PS_W | Bytes per page (at least 1) |
| byte_count | input | CNT_W | Requested image size in bytes |
| dest_base | input | ADDR_W | First destination address |
| ctl_en | output | 1 | Controller enable, high for the whole load |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dout | output | 8 | Command and address byte to flash |
| nand_din | input | 8 | Data byte from flash |
| nand_rb | input | 1 | Ready (1) / busy (0) from flash |
| mem_we | output | 1 | Destination write enable |
| mem_addr | output | ADDR_W | Destination address |
| mem_wdata | output | 8 | Destination write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong page counter or offset product shows up at once in the four address bytes of the next page. It also garbles every byte of that page at the destination port, because the flash model derives data from the latched address. A remaining-count error changes the number of chip-enable pulses and the total write count. This surfaces only at the end of the load, one page late or early. A broken ready guard becomes visible as a read strobe during the model's busy window, within a few cycles of the last address byte. A phase error in the strobe logic breaks the latch and exclusion properties on the first command cycle.

// File: rtl/nand_boot_pkg.sv
package nand_boot_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ENABLE, S_RST_CMD, S_RST_WAIT, S_RST_GAP,
    S_PG_CMD, S_PG_ADDR, S_PG_WAIT, S_PG_READ, S_PG_NEXT,
    S_OFF, S_DONE
  } seq_state_t;

  localparam logic [7:0] OP_RESET = 8'hFF;
  localparam logic [7:0] OP_READ  = 8'h00;
  localparam int         OFF_W    = 33;
endpackage

// File: rtl/nand_addr_gen.sv
module nand_addr_gen #(
  parameter int PAGE_W = 16,
  parameter int PS_W   = 12
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [PS_W-1:0]   page_size,
  input  logic [1:0]        idx,
  output logic [7:0]        addr_byte
);
  import nand_boot_pkg::*;

  logic [OFF_W-1:0] offset;

  // byte offset of the page; bit 8 is deliberately never transmitted
  assign offset = OFF_W'(page) * OFF_W'(page_size);

  always_comb begin
    unique case (idx)
      2'd0:    addr_byte = offset[7:0];
      2'd1:    addr_byte = offset[16:9];
      2'd2:    addr_byte = offset[24:17];
      default: addr_byte = offset[32:25];
    endcase
  end
endmodule

// File: rtl/nand_pin_drv.sv
module nand_pin_drv (
  input  logic       clk,
  input  logic       rst,
  input  logic       ce_i,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic       we_i,
  input  logic       re_i,
  input  logic [7:0] dout_i,
  output logic       ce_n,
  output logic       cle,
  output logic       ale,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ce_n <= 1'b1;
      cle  <= 1'b0;
      ale  <= 1'b0;
      we_n <= 1'b1;
      re_n <= 1'b1;
      dout <= '0;
    end else begin
      ce_n <= ~ce_i;
      cle  <= cle_i;
      ale  <= ale_i;
      we_n <= ~we_i;
      re_n <= ~re_i;
      dout <= dout_i;
    end
  end
endmodule

// File: rtl/nand_ready_wait.sv
module nand_ready_wait #(
  parameter int GAP = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic rb,
  output logic ready
);
  localparam int GW = $clog2(GAP + 1);

  logic [GW-1:0] gap_cnt;

  // the ready line is ignored for GAP cycles so the device can drop it
  always_ff @(posedge clk) begin
    if (rst || !active) gap_cnt <= GW'(GAP);
    else if (gap_cnt != '0) gap_cnt <= gap_cnt - GW'(1);
  end

  assign ready = active && (gap_cnt == '0) && rb;
endmodule

// File: rtl/nand_boot_seq.sv
module nand_boot_seq #(
  parameter int PAGE_W = 16,
  parameter int PS_W   = 12,
  parameter int CNT_W  = 20,
  parameter int ADDR_W = 20,
  parameter int WB_GAP = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PAGE_W-1:0] start_page,
  input  logic [PS_W-1:0]   page_size,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [ADDR_W-1:0] dest_base,
  output logic              ctl_en,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_dout,
  input  logic [7:0]        nand_din,
  input  logic              nand_rb,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              done
);
  import nand_boot_pkg::*;

  localparam int REM_W = ((CNT_W > PS_W) ? CNT_W : PS_W) + 1;

  seq_state_t              state;
  logic                    ph;
  logic [1:0]              aidx;
  logic [PAGE_W-1:0]       page;
  logic [PS_W-1:0]         ps_q;
  logic [PS_W-1:0]         col;
  logic [ADDR_W-1:0]       dest;
  logic signed [REM_W-1:0] remain;
  logic signed [REM_W-1:0] ps_s;
  logic signed [REM_W-1:0] rem_after;
  logic                    more;
  logic [7:0]              abyte;
  logic                    rdy;
  logic                    ce_i, cle_i, ale_i, we_i, re_i;
  logic [7:0]              dout_i;

  assign ps_s      = signed'(REM_W'(ps_q));
  assign rem_after = remain - ps_s;
  assign more      = !rem_after[REM_W-1];

  nand_addr_gen #(.PAGE_W(PAGE_W), .PS_W(PS_W)) u_addr (
    .page(page), .page_size(ps_q), .idx(aidx), .addr_byte(abyte)
  );

  nand_ready_wait #(.GAP(WB_GAP)) u_wait (
    .clk(clk), .rst(rst),
    .active(state == S_RST_WAIT || state == S_PG_WAIT),
    .rb(nand_rb), .ready(rdy)
  );

  // pin intent for the next cycle; the driver registers it
  always_comb begin
    ce_i   = state inside {S_RST_CMD, S_RST_WAIT, S_PG_CMD, S_PG_ADDR,
                           S_PG_WAIT, S_PG_READ};
    cle_i  = (state == S_RST_CMD) || (state == S_PG_CMD);
    ale_i  = (state == S_PG_ADDR);
    we_i   = (cle_i || ale_i) && !ph;
    re_i   = (state == S_PG_READ) && !ph;
    dout_i = (state == S_RST_CMD) ? OP_RESET :
             (state == S_PG_CMD)  ? OP_READ  : abyte;
  end

  nand_pin_drv u_pins (
    .clk(clk), .rst(rst),
    .ce_i(ce_i), .cle_i(cle_i), .ale_i(ale_i), .we_i(we_i), .re_i(re_i),
    .dout_i(dout_i),
    .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale),
    .we_n(nand_we_n), .re_n(nand_re_n), .dout(nand_dout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      ph        <= 1'b0;
      aidx      <= '0;
      page      <= '0;
      ps_q      <= '0;
      col       <= '0;
      dest      <= '0;
      remain    <= '0;
      ctl_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      done   <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          page   <= start_page;
          ps_q   <= page_size;
          remain <= signed'(REM_W'(byte_count));
          dest   <= dest_base;
          ctl_en <= 1'b1;
          state  <= S_ENABLE;
        end
        S_ENABLE: begin
          ph    <= 1'b0;
          state <= S_RST_CMD;
        end
        S_RST_CMD: begin
          ph <= !ph;
          if (ph) state <= S_RST_WAIT;
        end
        S_RST_WAIT: if (rdy) state <= S_RST_GAP;
        S_RST_GAP:  state <= S_PG_CMD;
        S_PG_CMD: begin
          ph <= !ph;
          if (ph) begin
            aidx  <= '0;
            state <= S_PG_ADDR;
          end
        end
        S_PG_ADDR: begin
          ph <= !ph;
          if (ph) begin
            if (aidx == 2'd3) state <= S_PG_WAIT;
            aidx <= aidx + 2'd1;
          end
        end
        S_PG_WAIT: if (rdy) begin
          col   <= '0;
          ph    <= 1'b0;
          state <= S_PG_READ;
        end
        S_PG_READ: begin
          ph <= !ph;
          if (ph) begin
            mem_we    <= 1'b1;
            mem_addr  <= dest;
            mem_wdata <= nand_din;
            dest      <= dest + ADDR_W'(1);
            col       <= col + PS_W'(1);
            if (col == ps_q - PS_W'(1)) state <= S_PG_NEXT;
          end
        end
        S_PG_NEXT: begin
          page   <= page + PAGE_W'(1);
          remain <= rem_after;
          state  <= more ? S_PG_CMD : S_OFF;
        end
        S_OFF: begin
          ctl_en <= 1'b0;
          state  <= S_DONE;
        end
        S_DONE: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_boot_chk.sv
module nand_boot_chk (
  input logic clk,
  input logic rst,
  input logic ctl_en,
  input logic nand_ce_n,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_we_n,
  input logic nand_re_n,
  input logic mem_we,
  input logic done
);
  p_latch_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale));
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_re_n));
  p_strobe_ce_r10: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (nand_ce_n && !ctl_en));
  p_done_after_off_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_en) |=> done);
  p_we_after_read_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($past(!nand_re_n) && ctl_en));
endmodule

bind nand_boot_seq nand_boot_chk u_chk (
  .clk(clk), .rst(rst), .ctl_en(ctl_en), .nand_ce_n(nand_ce_n),
  .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
  .nand_re_n(nand_re_n), .mem_we(mem_we), .done(done)
);

// File: tb/sim_nand_boot_seq.sv
`timescale 1ns/1ps
module sim_nand_boot_seq;
  localparam int PAGE_W = 16, PS_W = 12, CNT_W = 20, ADDR_W = 20;
  localparam int BUSY = 6;

  typedef struct packed {
    logic [PAGE_W-1:0] pg;
    logic [PS_W-1:0]   ps;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] dst;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{16'd5,     12'd16,   20'd40,  20'h00100},
    '{16'h3456,  12'd16,   20'd16,  20'h01000},
    '{16'd7,     12'd32,   20'd0,   20'h0ABC0},
    '{16'hFFFF,  12'hFFF,  20'd100, 20'h20000},
    '{16'd2,     12'd8,    20'd23,  20'hFFFF0}
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [PAGE_W-1:0] start_page = '0;
  logic [PS_W-1:0]   page_size = '0;
  logic [CNT_W-1:0]  byte_count = '0;
  logic [ADDR_W-1:0] dest_base = '0;
  logic ctl_en, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
  logic [7:0] nand_dout, nand_din;
  logic nand_rb;
  logic mem_we, done;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata;

  always #2.5 clk = ~clk;

  nand_boot_seq u0 (.*);

  int checks = 0, failures = 0, cycles = 0;

  function automatic logic [7:0] exp_ab(input int p, input int ps, input int i);
    logic [32:0] off;
    off = 33'(p) * 33'(ps);
    case (i)
      0: return off[7:0];
      1: return off[16:9];
      2: return off[24:17];
      default: return off[32:25];
    endcase
  endfunction

  function automatic logic [7:0] fdat(input logic [7:0] b0, b1, b2, b3,
                                      input int col);
    logic [11:0] c;
    c = 12'(col);
    return b0 ^ {b1[6:0], b1[7]} ^ (b2 * 8'd3) ^ b3 ^ c[7:0] ^ {c[11:8], 4'h5};
  endfunction

  // flash model and monitor state
  logic [7:0] mab [4];
  logic [7:0] alog [8][4];
  int busy_cnt, mcol, addr_n;
  int rst_cmds, rd_cmds, wr_cnt, wr_err, busy_rd, ce_rises, done_cnt;
  int cur_pg, cur_ps, cur_dst;
  logic we_q, re_q, ce_q;
  logic [ADDR_W-1:0] bad_addr_a, bad_addr_e;
  logic [7:0] bad_dat_a, bad_dat_e;

  assign nand_rb  = (busy_cnt == 0);
  assign nand_din = fdat(mab[0], mab[1], mab[2], mab[3], mcol);

  task automatic clear_mon();
    rst_cmds = 0; rd_cmds = 0; wr_cnt = 0; wr_err = 0; busy_rd = 0;
    ce_rises = 0; done_cnt = 0; addr_n = 0; mcol = 0; busy_cnt = 0;
    for (int i = 0; i < 4; i++) mab[i] = 8'h0;
    for (int i = 0; i < 8; i++) for (int j = 0; j < 4; j++) alog[i][j] = 8'h0;
  endtask

  initial clear_mon();

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      busy_cnt = 0; we_q = 1'b1; re_q = 1'b1; ce_q = 1'b1;
    end else begin
      if (busy_cnt > 0) busy_cnt--;
      if (!we_q && nand_we_n) begin
        if (nand_cle) begin
          if (nand_dout == 8'hFF) begin rst_cmds++; busy_cnt = BUSY; end
          if (nand_dout == 8'h00) begin rd_cmds++; addr_n = 0; end
        end
        if (nand_ale) begin
          if (addr_n < 4) mab[addr_n] = nand_dout;
          if (addr_n < 4 && rd_cmds >= 1 && rd_cmds <= 8)
            alog[rd_cmds-1][addr_n] = nand_dout;
          addr_n++;
          if (addr_n == 4) begin busy_cnt = BUSY; mcol = 0; end
        end
      end
      if (re_q && !nand_re_n && busy_cnt != 0) busy_rd++;
      if (!re_q && nand_re_n) mcol++;
      if (!ce_q && nand_ce_n) ce_rises++;
      if (done) done_cnt++;
      if (mem_we) begin
        int p, c;
        logic [ADDR_W-1:0] ea;
        logic [7:0] ed;
        p  = cur_pg + wr_cnt / cur_ps;
        c  = wr_cnt % cur_ps;
        ea = ADDR_W'(cur_dst + wr_cnt);
        ed = fdat(exp_ab(p, cur_ps, 0), exp_ab(p, cur_ps, 1),
                  exp_ab(p, cur_ps, 2), exp_ab(p, cur_ps, 3), c);
        if (mem_addr !== ea || mem_wdata !== ed) begin
          if (wr_err == 0) begin
            bad_addr_a = mem_addr; bad_addr_e = ea;
            bad_dat_a = mem_wdata; bad_dat_e = ed;
          end
          wr_err++;
        end
        wr_cnt++;
      end
      we_q = nand_we_n; re_q = nand_re_n; ce_q = nand_ce_n;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    checks++; failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
    finish_run();
  end

  task automatic pulse_start(input vec_t v);
    @(negedge clk);
    start_page = v.pg; page_size = v.ps; byte_count = v.cnt; dest_base = v.dst;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic check_run(input vec_t v, input bit fired);
    int pages, bad;
    pages = int'(v.cnt) / int'(v.ps) + 1;
    chk(fired, "R8", "done seen", fired, 1);
    chk(nand_ce_n == 1'b1 && ctl_en == 1'b0, "R8", "ce_n/ctl_en at done",
        {nand_ce_n, ctl_en}, 2);
    @(negedge clk);
    chk(done == 1'b0 && done_cnt == 1, "R8", "done single cycle", done_cnt, 1);
    chk(rst_cmds == 1, "R2", "reset opcode count", rst_cmds, 1);
    chk(rd_cmds == pages, "R7", "pages read", rd_cmds, pages);
    chk(wr_cnt == pages * int'(v.ps), "R7", "bytes written", wr_cnt,
        pages * int'(v.ps));
    chk(ce_rises == pages + 1, "R3", "chip enable releases", ce_rises, pages + 1);
    bad = 0;
    for (int i = 0; i < pages && i < 8; i++)
      for (int j = 0; j < 4; j++)
        if (alog[i][j] !== exp_ab(int'(v.pg) + i, int'(v.ps), j)) bad++;
    chk(bad == 0, "R4", "address byte mismatches", bad, 0);
    chk(wr_err == 0, "R6", "dest addr mismatches", bad_addr_a, bad_addr_e);
    chk(wr_err == 0, "R6", "dest data mismatches", bad_dat_a, bad_dat_e);
    chk(busy_rd == 0, "R5", "reads while busy", busy_rd, 0);
  endtask

  initial begin : main
    bit ok;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale &&
        !ctl_en && !mem_we && !done, "R1", "reset outputs",
        {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, ctl_en, mem_we, done},
        8'b11100000);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(nand_ce_n && !ctl_en && !done, "R1", "idle after reset",
        {nand_ce_n, ctl_en, done}, 3'b100);

    // table of vectors: R2 R3 R4 R5 R6 R7 R8
    for (int k = 0; k < NV; k++) begin
      clear_mon();
      cur_pg = int'(VECS[k].pg); cur_ps = int'(VECS[k].ps); cur_dst = int'(VECS[k].dst);
      pulse_start(VECS[k]);
      chk(ctl_en == 1'b1, "R2", "controller enabled", ctl_en, 1);
      wait_done(ok);
      check_run(VECS[k], ok);
    end

    // R9: second start while busy is ignored
    clear_mon();
    cur_pg = int'(VECS[0].pg); cur_ps = int'(VECS[0].ps); cur_dst = int'(VECS[0].dst);
    pulse_start(VECS[0]);
    repeat (30) @(negedge clk);
    pulse_start(VECS[4]);
    wait_done(ok);
    chk(rst_cmds == 1 && rd_cmds == 3, "R9", "restart ignored (reads)", rd_cmds, 3);
    check_run(VECS[0], ok);

    // R1: reset in the middle of a load
    clear_mon();
    cur_pg = int'(VECS[1].pg); cur_ps = int'(VECS[1].ps); cur_dst = int'(VECS[1].dst);
    pulse_start(VECS[1]);
    repeat (60) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(nand_ce_n && nand_we_n && nand_re_n && !ctl_en && !mem_we && !done,
        "R1", "mid-load reset", {nand_ce_n, ctl_en}, 2);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(ctl_en == 1'b0 && nand_ce_n == 1'b1, "R1", "stays idle after reset",
        ctl_en, 0);
    finish_run();
  end
endmodule